// File: doc/BRIEF.md
# Interrupt and Timeout Watchdog Unit

This unit sits beside a command/response mailbox and collects the conditions a host wants to be told about: response data waiting, room in the command queue, a malformed command, a packet that was opened but never closed, and a downstream consumer that has stalled for too long. Each condition is one bit of a status word. A host-programmed enable word masks that status word, and a single level interrupt is raised while any enabled condition is active.

Two programmable down-counting watchdogs supply the timeout conditions. The packet watchdog starts when a start-of-packet command word is accepted and stops when the end-of-packet word is accepted. The stall watchdog counts the cycles in which a command word is offered but not taken. An expiry latches a fatal status bit that stays set until reset. All registers sit on a simple 32-bit word-addressed port with a read strobe and a read-valid return.

Top module: `mbx_irq_wdt`

## Requirements
- R1: The enable word is at word address 7 and is read/write. Only its bits 0, 1, 3, 4 and 5 are stored; bit 2 and bits 31:6 read 0. A read returns its data with `reg_rvalid` high exactly one cycle after the `reg_rd` cycle; unmapped addresses (e.g. 3) read 0.
- R2: After reset the enable word and all latched status bits are 0, both timer words (address 9 packet watchdog, address 10 stall watchdog; bit 31 = enable, bits 30:0 = period) read 0x07FF_FFFF, and `irq` is low.
- R3: Status bit 0 equals `resp_has_data` and status bit 1 equals the inverse of `cmd_fifo_full`, with no clearing needed.
- R4: A one-cycle pulse on `cmd_invalid` sets status bit 3, which stays set after the input returns low.
- R5: `irq` is high exactly when some status bit and the enable bit at the same position are both 1.
- R6: With the packet watchdog enabled and period P, an accepted command word (`cmd_valid` and `cmd_ready`) with start flag set and end flag clear arms it; if no end-of-packet word is accepted, status bit 4 becomes 1 at the (P+1)th rising edge after the arming edge, and is 0 before it.
- R7: An accepted end-of-packet word disarms the packet watchdog, and a single word carrying both start and end flags does not arm it; in either case bit 4 stays 0.
- R8: With the stall watchdog enabled and period P, status bit 5 becomes 1 at the (P+1)th rising edge in which `cmd_valid` is high and `cmd_ready` low; an accepted word reloads the count, and idle cycles leave it unchanged.
- R9: A watchdog whose enable bit is 0 never sets its status bit, however long the packet stays open or the stall lasts.
- R10: The status word at address 8 is read-only: a write there changes nothing that reads back, and its bit 2 and bits 31:6 read 0.
- R11: Status bits 3, 4 and 5 are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, held at least 2 cycles |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| resp_has_data | input | 1 | Response queue holds at least one word |
| cmd_fifo_full | input | 1 | Command queue is full |
| cmd_invalid | input | 1 | Pulse from the packet checker: malformed command |
| cmd_valid | input | 1 | A command word is offered downstream |
| cmd_ready | input | 1 | Downstream takes the offered word |
| cmd_sop | input | 1 | Offered word starts a packet |
| cmd_eop | input | 1 | Offered word ends a packet |
| irq | output | 1 | Level interrupt: any enabled status bit set |

## Verification
The packet watchdog is driven with an open packet left to run out, a packet closed before the limit, a one-word packet and a disabled timer; these separate an off-by-one count, a missing disarm and an arm on a combined start/end word. The stall watchdog sees an unbroken stall, a stall split by one accepted word, and idle gaps, which tells a reload on acceptance apart from a reload on any gap. Register traffic is walked from a vector table covering writable, masked, read-only and unmapped addresses, and the level inputs and the invalid pulse are toggled to show which status bits track and which latch.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int TMR_PW = DATA_W - 1;
    localparam int IRQ_N  = 6;

    localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 4'd7;
    localparam logic [ADDR_W-1:0] OFS_IRQ_STAT  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_TMR_PKT   = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_TMR_STALL = 4'd10;

    localparam logic [TMR_PW-1:0] TMR_PERIOD_RST = 31'h7FF_FFFF;
    localparam logic [IRQ_N-1:0]  IRQ_EN_MASK    = 6'b111011;

    // Bit order matters: position n of this struct is status bit n.
    typedef struct packed {
        logic bp_to;       // 5
        logic eop_to;      // 4
        logic cmd_bad;     // 3
        logic spare;       // 2
        logic cmd_room;    // 1
        logic resp_avail;  // 0
    } irq_vec_t;

    typedef struct packed {
        logic              en;
        logic [TMR_PW-1:0] period;
    } tmr_cfg_t;

    typedef enum logic {
        WDT_PACKET,
        WDT_STALL
    } wdt_mode_e;

    function automatic logic irq_pending(irq_vec_t st, logic [IRQ_N-1:0] en);
        return |(st & en);
    endfunction

    function automatic logic [DATA_W-1:0] widen_status(irq_vec_t st);
        return {{(DATA_W-IRQ_N){1'b0}}, st};
    endfunction

endpackage

// File: rtl/mbx_wdt_timer.sv
module mbx_wdt_timer
    import mbx_irq_pkg::*;
#(
    parameter int        PW   = TMR_PW,
    parameter wdt_mode_e MODE = WDT_PACKET
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic [PW-1:0] cfg_period,
    input  logic          cfg_load,
    input  logic          word_valid,
    input  logic          word_ready,
    input  logic          word_sop,
    input  logic          word_eop,
    output logic          expired
);

    logic [PW-1:0] count_q;
    logic          armed_q;
    logic          accept;
    logic          pkt_start;
    logic          pkt_stop;
    logic          reload;
    logic          tick;

    always_comb begin
        accept    = word_valid && word_ready;
        pkt_start = accept && word_sop && !word_eop;
        pkt_stop  = accept && word_eop;
        if (MODE == WDT_PACKET) begin
            reload = !cfg_en || cfg_load || pkt_start || pkt_stop;
            tick   = armed_q && !pkt_stop;
        end else begin
            reload = !cfg_en || cfg_load || accept;
            tick   = word_valid && !word_ready;
        end
    end

    generate
        if (MODE == WDT_PACKET) begin : g_arm
            always_ff @(posedge clk) begin
                if (rst)
                    armed_q <= 1'b0;
                else if (pkt_stop)
                    armed_q <= 1'b0;
                else if (pkt_start)
                    armed_q <= 1'b1;
            end
        end else begin : g_noarm
            assign armed_q = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= TMR_PERIOD_RST[PW-1:0];
            expired <= 1'b0;
        end else begin
            if (reload)
                count_q <= cfg_period;
            else if (tick && count_q != '0)
                count_q <= count_q - 1'b1;
            if (cfg_en && tick && !reload && count_q == '0)
                expired <= 1'b1;
        end
    end

endmodule

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
    import mbx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              resp_has_data,
    input  logic              cmd_fifo_full,
    input  logic              cmd_invalid,
    input  logic              eop_to,
    input  logic              bp_to,
    output tmr_cfg_t          pkt_cfg,
    output tmr_cfg_t          stall_cfg,
    output logic              pkt_load,
    output logic              stall_load,
    output logic [IRQ_N-1:0]  ier_bits,
    output logic              irq
);

    logic     cmd_bad_q;
    irq_vec_t status;
    logic     wr_ier, wr_pkt, wr_stall;

    always_comb begin
        wr_ier   = reg_wr && reg_addr == OFS_IRQ_EN;
        wr_pkt   = reg_wr && reg_addr == OFS_TMR_PKT;
        wr_stall = reg_wr && reg_addr == OFS_TMR_STALL;

        status            = '0;
        status.resp_avail = resp_has_data;
        status.cmd_room   = !cmd_fifo_full;
        status.cmd_bad    = cmd_bad_q;
        status.eop_to     = eop_to;
        status.bp_to      = bp_to;

        irq = irq_pending(status, ier_bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_bits   <= '0;
            pkt_cfg    <= '{en: 1'b0, period: TMR_PERIOD_RST};
            stall_cfg  <= '{en: 1'b0, period: TMR_PERIOD_RST};
            pkt_load   <= 1'b0;
            stall_load <= 1'b0;
            cmd_bad_q  <= 1'b0;
        end else begin
            if (wr_ier)
                ier_bits <= reg_wdata[IRQ_N-1:0] & IRQ_EN_MASK;
            if (wr_pkt)
                pkt_cfg <= tmr_cfg_t'(reg_wdata);
            if (wr_stall)
                stall_cfg <= tmr_cfg_t'(reg_wdata);
            // load the new period one cycle after the write lands
            pkt_load   <= wr_pkt;
            stall_load <= wr_stall;
            if (cmd_invalid)
                cmd_bad_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                unique case (reg_addr)
                    OFS_IRQ_EN:    reg_rdata <= {{(DATA_W-IRQ_N){1'b0}}, ier_bits};
                    OFS_IRQ_STAT:  reg_rdata <= widen_status(status);
                    OFS_TMR_PKT:   reg_rdata <= pkt_cfg;
                    OFS_TMR_STALL: reg_rdata <= stall_cfg;
                    default:       reg_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbx_irq_wdt.sv
module mbx_irq_wdt
    import mbx_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              resp_has_data,
    input  logic              cmd_fifo_full,
    input  logic              cmd_invalid,
    input  logic              cmd_valid,
    input  logic              cmd_ready,
    input  logic              cmd_sop,
    input  logic              cmd_eop,
    output logic              irq
);

    tmr_cfg_t         pkt_cfg, stall_cfg;
    logic             pkt_load, stall_load;
    logic             eop_to, bp_to;
    logic [IRQ_N-1:0] ier_bits;

    mbx_irq_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .reg_rvalid    (reg_rvalid),
        .resp_has_data (resp_has_data),
        .cmd_fifo_full (cmd_fifo_full),
        .cmd_invalid   (cmd_invalid),
        .eop_to        (eop_to),
        .bp_to         (bp_to),
        .pkt_cfg       (pkt_cfg),
        .stall_cfg     (stall_cfg),
        .pkt_load      (pkt_load),
        .stall_load    (stall_load),
        .ier_bits      (ier_bits),
        .irq           (irq)
    );

    mbx_wdt_timer #(.PW(TMR_PW), .MODE(WDT_PACKET)) u_pkt_wdt (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (pkt_cfg.en),
        .cfg_period (pkt_cfg.period),
        .cfg_load   (pkt_load),
        .word_valid (cmd_valid),
        .word_ready (cmd_ready),
        .word_sop   (cmd_sop),
        .word_eop   (cmd_eop),
        .expired    (eop_to)
    );

    mbx_wdt_timer #(.PW(TMR_PW), .MODE(WDT_STALL)) u_stall_wdt (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (stall_cfg.en),
        .cfg_period (stall_cfg.period),
        .cfg_load   (stall_load),
        .word_valid (cmd_valid),
        .word_ready (cmd_ready),
        .word_sop   (cmd_sop),
        .word_eop   (cmd_eop),
        .expired    (bp_to)
    );

endmodule

// File: rtl/mbx_irq_wdt_chk.sv
module mbx_irq_wdt_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_rd,
    input logic       reg_rvalid,
    input logic       resp_has_data,
    input logic       irq,
    input logic [5:0] ier_bits,
    input logic       eop_to,
    input logic       bp_to,
    input logic       t1_en,
    input logic       t2_en
);

    // R1
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    // R1
    rvalid_only_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (ier_bits == 6'd0) |-> !irq);

    // R3
    data_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_has_data && ier_bits[0]) |-> irq);

    // R11
    eop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        eop_to |=> eop_to);

    // R11
    bp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bp_to |=> bp_to);

    // R9
    pkt_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!t1_en && !eop_to) |=> !eop_to);

    // R9
    stall_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!t2_en && !bp_to) |=> !bp_to);

endmodule

bind mbx_irq_wdt mbx_irq_wdt_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_rd        (reg_rd),
    .reg_rvalid    (reg_rvalid),
    .resp_has_data (resp_has_data),
    .irq           (irq),
    .ier_bits      (ier_bits),
    .eop_to        (eop_to),
    .bp_to         (bp_to),
    .t1_en         (pkt_cfg.en),
    .t2_en         (stall_cfg.en)
);

// File: tb/mbx_irq_wdt_test.sv
`timescale 1ns/1ps
module mbx_irq_wdt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        resp_has_data = 1'b0;
    logic        cmd_fifo_full = 1'b1;
    logic        cmd_invalid = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready = 1'b0;
    logic        cmd_sop = 1'b0;
    logic        cmd_eop = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbx_irq_wdt uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .resp_has_data(resp_has_data), .cmd_fifo_full(cmd_fifo_full),
        .cmd_invalid(cmd_invalid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sop(cmd_sop), .cmd_eop(cmd_eop), .irq(irq)
    );

    // {address, write data, expected read-back}
    localparam logic [67:0] VEC [0:5] = '{
        {4'd7,  32'hFFFF_FFFF, 32'h0000_003B},
        {4'd7,  32'h0000_0000, 32'h0000_0000},
        {4'd9,  32'h0000_1234, 32'h0000_1234},
        {4'd10, 32'h8000_0010, 32'h8000_0010},
        {4'd3,  32'hFFFF_FFFF, 32'h0000_0000},
        {4'd8,  32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_ready = 1'b0; cmd_sop = 1'b0; cmd_eop = 1'b0;
        cmd_invalid = 1'b0; resp_has_data = 1'b0; cmd_fifo_full = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        wait_cycles(1);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        wait_cycles(1);
        reg_rd = 1'b0;
        check("R1 rvalid", {31'd0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic send_word(input logic s, input logic e);
        cmd_valid = 1'b1; cmd_ready = 1'b1; cmd_sop = s; cmd_eop = e;
        wait_cycles(1);
        cmd_valid = 1'b0; cmd_ready = 1'b0; cmd_sop = 1'b0; cmd_eop = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        do_reset();

        // R2 reset state
        check("R2 irq", {31'd0, irq}, 32'd0);
        check("R2 rvalid idle", {31'd0, reg_rvalid}, 32'd0);
        do_read(4'd7, rd);  check("R2 enable word", rd, 32'h0);
        do_read(4'd8, rd);  check("R2 status word", rd, 32'h0);
        do_read(4'd9, rd);  check("R2 packet timer", rd, 32'h07FF_FFFF);
        do_read(4'd10, rd); check("R2 stall timer", rd, 32'h07FF_FFFF);
        wait_cycles(1);
        check("R1 rvalid drops", {31'd0, reg_rvalid}, 32'd0);

        // R1 / R10 table walk
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][67:64], VEC[i][63:32]);
            do_read(VEC[i][67:64], rd);
            check("R1/R10 table", rd, VEC[i][31:0]);
        end

        // R3 live status bits and R5 masking
        do_reset();
        resp_has_data = 1'b1;
        wait_cycles(1);
        check("R5 masked irq", {31'd0, irq}, 32'd0);
        do_read(4'd8, rd); check("R3 data bit", rd, 32'h1);
        do_write(4'd7, 32'h1);
        check("R5 irq data", {31'd0, irq}, 32'd1);
        resp_has_data = 1'b0; cmd_fifo_full = 1'b0;
        wait_cycles(1);
        check("R3 irq follows data", {31'd0, irq}, 32'd0);
        do_read(4'd8, rd); check("R3 room bit", rd, 32'h2);
        do_write(4'd7, 32'h2);
        check("R5 irq room", {31'd0, irq}, 32'd1);
        cmd_fifo_full = 1'b1;
        wait_cycles(1);
        check("R3 irq room clears", {31'd0, irq}, 32'd0);

        // R4 / R11 command invalid latch
        do_write(4'd7, 32'h8);
        cmd_invalid = 1'b1;
        wait_cycles(1);
        cmd_invalid = 1'b0;
        wait_cycles(3);
        check("R4 invalid latched irq", {31'd0, irq}, 32'd1);
        do_write(4'd8, 32'h0);
        do_read(4'd8, rd); check("R10/R11 invalid stays", rd, 32'h8);
        do_reset();
        do_read(4'd8, rd); check("R11 reset clears", rd, 32'h0);

        // R6 packet watchdog expiry at edge P+1
        do_write(4'd7, 32'h10);
        do_write(4'd9, 32'h8000_0005);
        send_word(1'b1, 1'b0);
        wait_cycles(5);
        check("R6 not yet expired", {31'd0, irq}, 32'd0);
        wait_cycles(1);
        check("R6 expired", {31'd0, irq}, 32'd1);
        send_word(1'b0, 1'b1);
        wait_cycles(2);
        check("R11 eop timeout sticky", {31'd0, irq}, 32'd1);
        do_read(4'd8, rd); check("R6 status bit4", rd, 32'h10);

        // R7 packet closed in time, single-word packet
        do_reset();
        do_write(4'd7, 32'h10);
        do_write(4'd9, 32'h8000_0005);
        send_word(1'b1, 1'b0);
        wait_cycles(3);
        send_word(1'b0, 1'b1);
        wait_cycles(12);
        check("R7 eop disarms", {31'd0, irq}, 32'd0);
        send_word(1'b1, 1'b1);
        wait_cycles(12);
        check("R7 single word", {31'd0, irq}, 32'd0);

        // R8 stall watchdog
        do_reset();
        do_write(4'd7, 32'h20);
        do_write(4'd10, 32'h8000_0004);
        wait_cycles(2);
        cmd_valid = 1'b1; cmd_ready = 1'b0;
        wait_cycles(4);
        check("R8 not yet expired", {31'd0, irq}, 32'd0);
        wait_cycles(1);
        check("R8 expired", {31'd0, irq}, 32'd1);
        cmd_valid = 1'b0;
        wait_cycles(3);
        do_read(4'd8, rd); check("R11 bp sticky", rd, 32'h20);

        do_reset();
        do_write(4'd7, 32'h20);
        do_write(4'd10, 32'h8000_0004);
        wait_cycles(2);
        cmd_valid = 1'b1; cmd_ready = 1'b0;
        wait_cycles(3);
        cmd_ready = 1'b1;
        wait_cycles(1);
        cmd_ready = 1'b0;
        wait_cycles(3);
        check("R8 accept reloads", {31'd0, irq}, 32'd0);
        cmd_valid = 1'b0;
        wait_cycles(6);
        cmd_valid = 1'b1;
        wait_cycles(1);
        check("R8 idle holds count", {31'd0, irq}, 32'd0);
        wait_cycles(1);
        check("R8 expiry after idle gap", {31'd0, irq}, 32'd1);
        cmd_valid = 1'b0;

        // R9 disabled timers
        do_reset();
        do_write(4'd7, 32'h30);
        do_write(4'd9, 32'h0000_0002);
        do_write(4'd10, 32'h0000_0002);
        send_word(1'b1, 1'b0);
        cmd_valid = 1'b1; cmd_ready = 1'b0;
        wait_cycles(12);
        cmd_valid = 1'b0;
        check("R9 disabled irq", {31'd0, irq}, 32'd0);
        do_read(4'd8, rd); check("R9 disabled status", rd, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule